// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block tells an SDRAM controller when an auto-refresh is due. A three-bit mode code, written through a simple write strobe, turns refresh on or off and picks the spacing between requests. Two codes give intervals set in time, 15.6 µs and 7.8 µs. These are turned into whole clock counts when the design is elaborated, from a parameter that gives the clock frequency in MHz, rounding down. A third code gives a fast setting of a fixed number of controller clocks. Every other code leaves refresh off.

When an interval runs out, the block raises a request. The request stays high until the controller acknowledges it, and the next interval is then counted from that acknowledge. If a whole interval passes while a request is still waiting, a sticky overrun flag is set. A write that changes the mode code restarts the count and withdraws any pending request.

Top module: `sdram_refresh_timer`

## Requirements
- R1: After reset the mode code is 000, `refresh_req` is low and `overrun` is low.
- R2: Code 001 raises `refresh_req` floor(CLK_MHZ×15.6) clock edges after the edge that accepts the write or acknowledge that started the interval.
- R3: Code 010 raises `refresh_req` floor(CLK_MHZ×7.8) clock edges after the starting edge.
- R4: Code 111 raises `refresh_req` FAST_CLKS clock edges (default 128) after the starting edge.
- R5: Code 000 and the codes 011, 100, 101 and 110 produce no request, however long the mode is held.
- R6: Once raised, `refresh_req` stays high until an acknowledge or a mode change.
- R7: An edge with `refresh_ack` high while a request is pending drops `refresh_req` after that edge, and a new interval is counted from that edge. An acknowledge with no request pending has no effect on timing.
- R8: A write whose data differs from the current code drops `refresh_req` and restarts the count from the write edge. A write of the code already held changes nothing.
- R9: If the interval runs out again while a request is still pending, `overrun` goes high after that edge and stays high until reset. The request stays raised.
- R10: An acknowledge on the same edge where the interval runs out with a request pending is accepted. The request drops, `overrun` is not set and a new interval starts from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode code |
| mode_wdata | input | 3 | New mode code |
| refresh_ack | input | 1 | Controller accepts the pending request |
| refresh_req | output | 1 | Refresh request, held until acknowledged |
| overrun | output | 1 | Sticky flag: an interval ran out with a request still pending |

## Verification
Two events can fall on the same clock edge: the controller's acknowledge and the end of the next interval while a request is still pending. The bench provokes this in the fast mode. It leaves a request unanswered and drives the acknowledge so that it is sampled exactly FAST_CLKS edges after the request rose. It then expects the request to drop, `overrun` to stay low and the next request to arrive a full interval after that edge. A mode write that lands on a pending request is treated the same way: the withdrawn request and the restarted timing are checked against the cycles predicted by the scoreboard.

// File: rtl/refresh_tmr_pkg.sv
package refresh_tmr_pkg;

    typedef enum logic [2:0] {
        RM_OFF  = 3'b000,
        RM_SLOW = 3'b001,
        RM_NORM = 3'b010,
        RM_RSV3 = 3'b011,
        RM_RSV4 = 3'b100,
        RM_RSV5 = 3'b101,
        RM_RSV6 = 3'b110,
        RM_FAST = 3'b111
    } rmode_e;

    // Interval lengths in tenths of a microsecond
    localparam int SLOW_TENTHS_US = 156;
    localparam int NORM_TENTHS_US = 78;

    typedef struct packed {
        logic req;
        logic overrun;
    } req_state_t;

    typedef struct packed {
        logic active;
        logic clear;
    } cnt_ctrl_t;

    // Whole clocks in a time span, rounded down
    function automatic int clocks_for(input int clk_mhz, input int tenths_us);
        return (clk_mhz * tenths_us) / 10;
    endfunction

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic logic mode_runs(input rmode_e m);
        return (m == RM_SLOW) || (m == RM_NORM) || (m == RM_FAST);
    endfunction

endpackage

// File: rtl/refresh_mode_reg.sv
module refresh_mode_reg
    import refresh_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [2:0] wdata,
    output rmode_e     mode_q,
    output logic       changed
);

    rmode_e wmode;

    always_comb begin
        wmode   = rmode_e'(wdata);
        changed = wr && (wmode != mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RM_OFF;
        end else if (changed) begin
            mode_q <= wmode;
        end
    end

endmodule

// File: rtl/refresh_interval_sel.sv
module refresh_interval_sel
    import refresh_tmr_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int FAST_CLKS = 128,
    parameter int CNT_W     = 11
) (
    input  rmode_e           mode,
    output logic             active,
    output logic [CNT_W-1:0] last
);

    localparam int N_SLOW = clocks_for(CLK_MHZ, SLOW_TENTHS_US);
    localparam int N_NORM = clocks_for(CLK_MHZ, NORM_TENTHS_US);
    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(N_SLOW - 1);
    localparam logic [CNT_W-1:0] LAST_NORM = CNT_W'(N_NORM - 1);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(FAST_CLKS - 1);

    always_comb begin
        active = mode_runs(mode);
        unique case (mode)
            RM_SLOW: last = LAST_SLOW;
            RM_NORM: last = LAST_NORM;
            RM_FAST: last = LAST_FAST;
            default: last = '0;
        endcase
    end

endmodule

// File: rtl/refresh_interval_cnt.sv
module refresh_interval_cnt
    import refresh_tmr_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] last,
    output logic             expire,
    output logic [CNT_W-1:0] count
);

    assign expire = ctrl.active && !ctrl.clear && (count == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (ctrl.clear || !ctrl.active || expire) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/refresh_req_ctrl.sv
module refresh_req_ctrl
    import refresh_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_chg,
    input  logic       ack,
    input  logic       expire,
    output req_state_t st
);

    req_state_t nxt;

    always_comb begin
        nxt = st;
        if (mode_chg) begin
            nxt.req = 1'b0;
        end else if (st.req && ack) begin
            nxt.req = 1'b0;
        end else if (expire) begin
            nxt.req = 1'b1;
            if (st.req) nxt.overrun = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nxt;
        end
    end

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
    import refresh_tmr_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int FAST_CLKS = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       refresh_ack,
    output logic       refresh_req,
    output logic       overrun
);

    localparam int N_MAX = max_of3(clocks_for(CLK_MHZ, SLOW_TENTHS_US),
                                   clocks_for(CLK_MHZ, NORM_TENTHS_US),
                                   FAST_CLKS);
    localparam int CNT_W = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    rmode_e           mode_q;
    logic             mode_chg;
    logic             active;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] count;
    logic             expire;
    cnt_ctrl_t        cctl;
    req_state_t       rst_st;

    refresh_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr      (mode_wr),
        .wdata   (mode_wdata),
        .mode_q  (mode_q),
        .changed (mode_chg)
    );

    refresh_interval_sel #(
        .CLK_MHZ   (CLK_MHZ),
        .FAST_CLKS (FAST_CLKS),
        .CNT_W     (CNT_W)
    ) u_sel (
        .mode   (mode_q),
        .active (active),
        .last   (last)
    );

    always_comb begin
        cctl.active = active;
        cctl.clear  = mode_chg || (rst_st.req && refresh_ack);
    end

    refresh_interval_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (cctl),
        .last   (last),
        .expire (expire),
        .count  (count)
    );

    refresh_req_ctrl u_req (
        .clk      (clk),
        .rst      (rst),
        .mode_chg (mode_chg),
        .ack      (refresh_ack),
        .expire   (expire),
        .st       (rst_st)
    );

    assign refresh_req = rst_st.req;
    assign overrun     = rst_st.overrun;

endmodule

// File: rtl/sdram_refresh_timer_chk.sv
module sdram_refresh_timer_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             refresh_ack,
    input logic             refresh_req,
    input logic             overrun,
    input logic             mode_chg,
    input logic             active,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] last
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!refresh_req && !overrun && !active));

    a_r5_off_silent: assert property (@(posedge clk) disable iff (rst)
        !active |-> (!refresh_req && count == '0));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (count <= last));

    a_r6_req_holds: assert property (@(posedge clk) disable iff (rst)
        (refresh_req && !refresh_ack && !mode_chg) |=> refresh_req);

    a_r7_ack_releases: assert property (@(posedge clk) disable iff (rst)
        (refresh_req && refresh_ack && !mode_chg) |=> (!refresh_req && count == '0));

    a_r8_change_restarts: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (!refresh_req && count == '0));

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    a_r10_ack_beats_expiry: assert property (@(posedge clk) disable iff (rst)
        (refresh_req && refresh_ack && !overrun) |=> !overrun);

endmodule

bind sdram_refresh_timer sdram_refresh_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .refresh_ack (refresh_ack),
    .refresh_req (refresh_req),
    .overrun     (overrun),
    .mode_chg    (mode_chg),
    .active      (active),
    .count       (count),
    .last        (last)
);

// File: tb/sdram_refresh_timer_tb_top.sv
module sdram_refresh_timer_tb_top;

    localparam int MHZ    = 250;
    localparam int N_SLOW = MHZ * 156 / 10;
    localparam int N_NORM = MHZ * 78 / 10;
    localparam int N_FAST = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic       refresh_ack = 1'b0;
    logic       refresh_req;
    logic       overrun;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int    qr_cyc[$];
    string qr_tag[$];
    int    qo_cyc[$];
    string qo_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_refresh_timer #(.CLK_MHZ(MHZ), .FAST_CLKS(N_FAST)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .refresh_ack (refresh_ack),
        .refresh_req (refresh_req),
        .overrun     (overrun)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Monitor: pops expected rise cycles as the outputs rise
    logic req_d = 1'b0;
    logic ovr_d = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (refresh_req && !req_d) begin
                if (qr_cyc.size() == 0) begin
                    check(1'b0, "R5", "unexpected request at cycle", cyc, -1);
                end else begin
                    int    e;
                    string t;
                    e = qr_cyc.pop_front();
                    t = qr_tag.pop_front();
                    check(cyc == e, t, "request rise cycle", cyc, e);
                end
            end
            if (overrun && !ovr_d) begin
                if (qo_cyc.size() == 0) begin
                    check(1'b0, "R10", "unexpected overrun at cycle", cyc, -1);
                end else begin
                    int    e;
                    string t;
                    e = qo_cyc.pop_front();
                    t = qo_tag.pop_front();
                    check(cyc == e, t, "overrun rise cycle", cyc, e);
                end
            end
        end
        req_d = refresh_req;
        ovr_d = overrun;
    end

    task automatic push_req(input int c, input string t);
        qr_cyc.push_back(c);
        qr_tag.push_back(t);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drive_mode(input logic [2:0] code, output int w);
        w          = cyc + 1;
        mode_wr    = 1'b1;
        mode_wdata = code;
        @(negedge clk);
        mode_wr    = 1'b0;
    endtask

    task automatic drive_ack(output int a);
        a           = cyc + 1;
        refresh_ack = 1'b1;
        @(negedge clk);
        refresh_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int w, a, r, r2, r3, x;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(refresh_req == 1'b0, "R1", "req after reset", refresh_req, 0);
        check(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);

        // R5: the reserved codes stay silent
        foreach (dut_codes[i]) begin
            drive_mode(dut_codes[i], w);
            wait_until(w + N_SLOW + 10);
            check(refresh_req == 1'b0, "R5", "req in reserved code", refresh_req, 0);
        end

        // R4: fast mode
        drive_mode(3'b111, w);
        r = w + N_FAST;
        push_req(r, "R4");
        wait_until(r + 40);
        check(refresh_req == 1'b1, "R6", "req held without ack", refresh_req, 1);
        drive_ack(a);
        check(refresh_req == 1'b0, "R7", "req after ack", refresh_req, 0);
        r2 = a + N_FAST;
        push_req(r2, "R7");
        // ack with nothing pending: ignored
        wait_until(a + 50);
        drive_ack(x);
        check(refresh_req == 1'b0, "R7", "req after idle ack", refresh_req, 0);

        // R10: ack on the expiry edge
        wait_until(r2 + N_FAST - 1);
        drive_ack(a);
        check(a == r2 + N_FAST, "R10", "ack edge alignment", a, r2 + N_FAST);
        check(refresh_req == 1'b0, "R10", "req after coincident ack", refresh_req, 0);
        check(overrun == 1'b0, "R10", "overrun after coincident ack", overrun, 0);
        r3 = a + N_FAST;
        push_req(r3, "R10");

        // R8: mode change withdraws a pending request
        wait_until(r3 + 10);
        check(refresh_req == 1'b1, "R6", "req pending before change", refresh_req, 1);
        drive_mode(3'b010, w);
        check(refresh_req == 1'b0, "R8", "req after mode change", refresh_req, 0);
        push_req(w + N_NORM, "R3");
        wait_until(w + 1000);
        drive_mode(3'b010, x);
        wait_until(w + N_NORM + 5);
        check(refresh_req == 1'b1, "R3", "req after normal interval", refresh_req, 1);

        // R2: slow interval
        drive_mode(3'b001, w);
        check(refresh_req == 1'b0, "R8", "req after change to slow", refresh_req, 0);
        push_req(w + N_SLOW, "R2");
        wait_until(w + N_SLOW + 3);
        drive_ack(a);
        push_req(a + N_SLOW, "R2");
        wait_until(a + N_SLOW + 3);
        drive_ack(a);

        // R5: code 000 after running
        wait_until(a + 2000);
        drive_mode(3'b000, w);
        wait_until(w + N_SLOW + 10);
        check(refresh_req == 1'b0, "R5", "req in code 000", refresh_req, 0);

        // R9: overrun
        drive_mode(3'b111, w);
        r = w + N_FAST;
        push_req(r, "R4");
        qo_cyc.push_back(r + N_FAST);
        qo_tag.push_back("R9");
        wait_until(r + N_FAST + 5);
        check(overrun == 1'b1, "R9", "overrun set", overrun, 1);
        check(refresh_req == 1'b1, "R9", "req kept on overrun", refresh_req, 1);
        drive_ack(a);
        @(negedge clk);
        check(overrun == 1'b1, "R9", "overrun sticky after ack", overrun, 1);
        check(refresh_req == 1'b0, "R7", "req after late ack", refresh_req, 0);
        push_req(a + N_FAST, "R7");
        wait_until(a + N_FAST + 2);
        drive_mode(3'b000, w);
        wait_until(w + 200);
        check(overrun == 1'b1, "R9", "overrun sticky after mode change", overrun, 1);

        check(qr_cyc.size() == 0, "R6", "missing requests", qr_cyc.size(), 0);
        check(qo_cyc.size() == 0, "R9", "missing overruns", qo_cyc.size(), 0);
        done = 1'b1;
        finish_run();
    end

    logic [2:0] dut_codes [4] = '{3'b011, 3'b100, 3'b101, 3'b110};

endmodule